// File: doc/BRIEF.md
# Burst Handshake Latency Monitor

This block watches one burst bus and checks how quickly each side answers in every data phase. The inputs are the transaction frame, the initiator-ready, target-ready and target-stop signals, all active high. The bus drives them, and the block only observes. A flag on the first clock of a transaction tells the block that the access is a host-bridge access that hits a modified cache line. That access gets a longer first-phase allowance for the target.

The initiator has a fixed allowance in every data phase. The target has one allowance for the first data phase, a longer one for a modified-line hit, and a third for every later phase. Going past any allowance sets a sticky flag, and each limit has its own flag. The block also counts each transaction's clocks and data phases. It checks the clock total against the worst case that the phase count allows.

Top module: `burst_lat_mon`

## Requirements
- R1: After reset, every violation flag, `txnClocks`, `txnPhases` and `txnDone` read 0.
- R2: A transaction starts on a clock where `frameAct` is high and no transaction is in progress. `modHit` is sampled only on that clock. While a transaction runs, `frameAct` does not start a new one.
- R3: A data phase completes on a clock where `irdyAct` is high together with `trdyAct` or `stopAct`. The next clock is the first clock of the next phase. `txnPhases` counts completed phases.
- R4: In every phase, `irdyAct` must be high by the 8th clock of the phase. If the 8th clock passes without it, `mstrViol` is set. `irdyAct` on the 8th clock is still in time.
- R5: In the first phase of a transaction without a modified-line hit, `trdyAct` or `stopAct` must be high by the 16th clock counted from the start clock. Otherwise `tgtInitViol` is set.
- R6: When `modHit` was high on the start clock, the first-phase target allowance is 32 clocks. A late answer sets `tgtInitExtViol`, and `tgtInitViol` is not set.
- R7: In every phase after the first, `trdyAct` or `stopAct` must be high by the 8th clock of the phase. Otherwise `tgtSubViol` is set.
- R8: `stopAct` counts as a target answer and as a phase completion in the same way as `trdyAct`.
- R9: A transaction ends when a phase completes while `frameAct` is low. `txnDone` is high for exactly the one clock after that. From then on, `txnClocks` holds the transaction's clocks plus one idle clock, and `txnPhases` holds the phase count, until the next start. One clock after a start, `txnClocks` reads 1 and `txnPhases` reads 0.
- R10: For a transaction with n phases, `lenViol` is set at the end if the transaction's clocks exceed L + 8·(n−1). L is 16, or 32 for a modified-line hit.
- R11: Every violation flag stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameAct | input | 1 | Transaction frame asserted |
| irdyAct | input | 1 | Initiator ready asserted |
| trdyAct | input | 1 | Target ready asserted |
| stopAct | input | 1 | Target stop asserted |
| modHit | input | 1 | Host-bridge access hits a modified line (sampled at start) |
| mstrViol | output | 1 | Sticky: initiator answered late |
| tgtInitViol | output | 1 | Sticky: target late in first phase, normal limit |
| tgtInitExtViol | output | 1 | Sticky: target late in first phase, extended limit |
| tgtSubViol | output | 1 | Sticky: target late in a later phase |
| lenViol | output | 1 | Sticky: transaction longer than its worst-case bound |
| txnClocks | output | CNT_W | Clocks of the current or last transaction (plus idle at end) |
| txnPhases | output | PH_W | Completed data phases of the current or last transaction |
| txnDone | output | 1 | One-clock pulse after a transaction ends |

## Verification
The assertions assume that the bus behaves as a burst bus does: a transaction opens with `frameAct` high for at least one clock, and ready signals stay high once raised until their phase completes. The phase-count and clock-count properties also assume that a transaction ends by completing a phase while the frame is low. The stimulus builds every transaction phase by phase. It raises each ready at a chosen clock, holds it until completion, keeps the frame high on every clock except those of the final phase, and leaves at least one idle clock between transactions.

// File: rtl/burst_lat_pkg.sv
package burst_lat_pkg;

  // Strobes passed from the control FSM to the counting datapath
  typedef struct packed {
    logic active;     // clock belongs to a transaction
    logic start;      // first clock of a transaction
    logic complete;   // a data phase completes this clock
    logic finish;     // final data phase completes this clock
    logic initPhase;  // current phase is the first one
    logic extLim;     // extended first-phase target allowance applies
  } strobe_t;

endpackage

// File: rtl/burst_lat_ctrl.sv
module burst_lat_ctrl
  import burst_lat_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    frameAct,
  input  logic    irdyAct,
  input  logic    trdyAct,
  input  logic    stopAct,
  input  logic    modHit,
  output strobe_t strb
);

  typedef enum logic {S_IDLE, S_BUSY} state_t;

  state_t state;
  logic   initReg;
  logic   modReg;

  always_comb begin
    strb           = '0;
    strb.start     = (state == S_IDLE) && frameAct;
    strb.active    = strb.start || (state == S_BUSY);
    strb.complete  = strb.active && irdyAct && (trdyAct || stopAct);
    strb.finish    = (state == S_BUSY) && strb.complete && !frameAct;
    strb.initPhase = strb.start || initReg;
    strb.extLim    = strb.start ? modHit : modReg;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      initReg <= 1'b0;
      modReg  <= 1'b0;
    end else if (strb.start) begin
      state   <= S_BUSY;
      modReg  <= modHit;
      initReg <= !strb.complete;
    end else if (state == S_BUSY) begin
      if (strb.complete) initReg <= 1'b0;
      if (strb.finish)   state   <= S_IDLE;
    end
  end

  // R2
  start_only_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.start |=> (state == S_BUSY));

endmodule

// File: rtl/burst_lat_wait.sv
module burst_lat_wait #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         active,
  input  logic         clear,
  input  logic         resp,
  input  logic [W-1:0] limit,
  output logic         over
);

  logic [W-1:0] cnt;
  logic         seen;

  // over fires on the last allowed clock when no answer has come yet
  assign over = active && !seen && !resp && (cnt == (limit - W'(1)));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt  <= '0;
      seen <= 1'b0;
    end else if (active) begin
      if (clear) begin
        cnt  <= '0;
        seen <= 1'b0;
      end else if (resp) begin
        seen <= 1'b1;
      end else if (cnt != '1) begin
        cnt <= cnt + W'(1);
      end
    end
  end

  // R3
  cleared_after_phase_chk: assert property (@(posedge clk) disable iff (!rstN)
    (active && clear) |=> (cnt == '0 && !seen));

endmodule

// File: rtl/burst_lat_dp.sv
module burst_lat_dp
  import burst_lat_pkg::*;
#(
  parameter int MSTR_LIM = 8,
  parameter int INIT_LIM = 16,
  parameter int EXT_LIM  = 32,
  parameter int SUB_LIM  = 8,
  parameter int CNT_W    = 16,
  parameter int PH_W     = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strb,
  input  logic             irdyAct,
  input  logic             trdyAct,
  input  logic             stopAct,
  output logic             mstrViol,
  output logic             tgtInitViol,
  output logic             tgtInitExtViol,
  output logic             tgtSubViol,
  output logic             lenViol,
  output logic [CNT_W-1:0] txnClocks,
  output logic [PH_W-1:0]  txnPhases,
  output logic             txnDone
);

  localparam int MAX_LIM = (EXT_LIM > INIT_LIM) ? EXT_LIM : INIT_LIM;
  localparam int WAIT_W  = $clog2(MAX_LIM + 1) + 1;
  localparam int NCHK    = 2;

  logic [WAIT_W-1:0] limVec  [NCHK];
  logic              respVec [NCHK];
  logic              overVec [NCHK];
  logic [CNT_W-1:0]  initBudget;
  logic [CNT_W-1:0]  clkCnt;
  logic [CNT_W-1:0]  budget;
  logic [PH_W-1:0]   phCnt;
  logic [4:0]        violVec;

  // index 0: initiator, index 1: target
  assign limVec[0]  = WAIT_W'(MSTR_LIM);
  assign limVec[1]  = strb.initPhase ? (strb.extLim ? WAIT_W'(EXT_LIM) : WAIT_W'(INIT_LIM))
                                     : WAIT_W'(SUB_LIM);
  assign respVec[0] = irdyAct;
  assign respVec[1] = trdyAct || stopAct;

  for (genvar g = 0; g < NCHK; g++) begin : g_wait
    burst_lat_wait #(.W(WAIT_W)) u_wait (
      .clk   (clk),
      .rstN  (rstN),
      .active(strb.active),
      .clear (strb.complete),
      .resp  (respVec[g]),
      .limit (limVec[g]),
      .over  (overVec[g])
    );
  end

  assign initBudget = strb.extLim ? CNT_W'(EXT_LIM) : CNT_W'(INIT_LIM);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mstrViol       <= 1'b0;
      tgtInitViol    <= 1'b0;
      tgtInitExtViol <= 1'b0;
      tgtSubViol     <= 1'b0;
    end else begin
      if (overVec[0]) mstrViol <= 1'b1;
      if (overVec[1]) begin
        if (!strb.initPhase)  tgtSubViol     <= 1'b1;
        else if (strb.extLim) tgtInitExtViol <= 1'b1;
        else                  tgtInitViol    <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      clkCnt  <= '0;
      phCnt   <= '0;
      budget  <= '0;
      lenViol <= 1'b0;
      txnDone <= 1'b0;
    end else begin
      txnDone <= strb.finish;
      if (strb.start) begin
        clkCnt <= CNT_W'(1);
        phCnt  <= PH_W'(strb.complete);
        budget <= initBudget + (strb.complete ? CNT_W'(SUB_LIM) : '0);
      end else if (strb.active) begin
        clkCnt <= clkCnt + CNT_W'(1) + CNT_W'(strb.finish);
        phCnt  <= phCnt + PH_W'(strb.complete);
        if (strb.complete && !strb.finish) budget <= budget + CNT_W'(SUB_LIM);
        if (strb.finish && ((clkCnt + CNT_W'(1)) > budget)) lenViol <= 1'b1;
      end
    end
  end

  assign txnClocks = clkCnt;
  assign txnPhases = phCnt;
  assign violVec   = {lenViol, tgtSubViol, tgtInitExtViol, tgtInitViol, mstrViol};

  // R11
  for (genvar s = 0; s < 5; s++) begin : g_sticky
    sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
      violVec[s] |=> violVec[s]);
  end

  // R10
  len_needs_phase_chk: assert property (@(posedge clk) disable iff (!rstN)
    lenViol |-> (mstrViol || tgtInitViol || tgtInitExtViol || tgtSubViol));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    txnDone |=> !txnDone);

  // R3
  done_phases_chk: assert property (@(posedge clk) disable iff (!rstN)
    txnDone |-> (txnPhases != '0));

  // R9
  done_clocks_chk: assert property (@(posedge clk) disable iff (!rstN)
    txnDone |-> (txnClocks > CNT_W'(txnPhases)));

endmodule

// File: rtl/burst_lat_mon.sv
module burst_lat_mon
  import burst_lat_pkg::*;
#(
  parameter int MSTR_LIM = 8,
  parameter int INIT_LIM = 16,
  parameter int EXT_LIM  = 32,
  parameter int SUB_LIM  = 8,
  parameter int CNT_W    = 16,
  parameter int PH_W     = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             frameAct,
  input  logic             irdyAct,
  input  logic             trdyAct,
  input  logic             stopAct,
  input  logic             modHit,
  output logic             mstrViol,
  output logic             tgtInitViol,
  output logic             tgtInitExtViol,
  output logic             tgtSubViol,
  output logic             lenViol,
  output logic [CNT_W-1:0] txnClocks,
  output logic [PH_W-1:0]  txnPhases,
  output logic             txnDone
);

  strobe_t strb;

  burst_lat_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .frameAct(frameAct),
    .irdyAct (irdyAct),
    .trdyAct (trdyAct),
    .stopAct (stopAct),
    .modHit  (modHit),
    .strb    (strb)
  );

  burst_lat_dp #(
    .MSTR_LIM(MSTR_LIM), .INIT_LIM(INIT_LIM), .EXT_LIM(EXT_LIM),
    .SUB_LIM(SUB_LIM), .CNT_W(CNT_W), .PH_W(PH_W)
  ) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .strb          (strb),
    .irdyAct       (irdyAct),
    .trdyAct       (trdyAct),
    .stopAct       (stopAct),
    .mstrViol      (mstrViol),
    .tgtInitViol   (tgtInitViol),
    .tgtInitExtViol(tgtInitExtViol),
    .tgtSubViol    (tgtSubViol),
    .lenViol       (lenViol),
    .txnClocks     (txnClocks),
    .txnPhases     (txnPhases),
    .txnDone       (txnDone)
  );

endmodule

// File: tb/burst_lat_mon_bench.sv
module burst_lat_mon_bench;

  logic        clk = 1'b0;
  logic        rstN;
  logic        frameAct, irdyAct, trdyAct, stopAct, modHit;
  logic        mstrViol, tgtInitViol, tgtInitExtViol, tgtSubViol, lenViol;
  logic [15:0] txnClocks;
  logic [11:0] txnPhases;
  logic        txnDone;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  bit eM, eTI, eTX, eTS, eL;

  always #2.5 clk = ~clk;

  burst_lat_mon u_burst_lat_mon (
    .clk(clk), .rstN(rstN), .frameAct(frameAct), .irdyAct(irdyAct),
    .trdyAct(trdyAct), .stopAct(stopAct), .modHit(modHit),
    .mstrViol(mstrViol), .tgtInitViol(tgtInitViol), .tgtInitExtViol(tgtInitExtViol),
    .tgtSubViol(tgtSubViol), .lenViol(lenViol), .txnClocks(txnClocks),
    .txnPhases(txnPhases), .txnDone(txnDone)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic checkFlags(input string req);
    check({req, " mstrViol"}, int'(mstrViol), int'(eM));
    check({req, " tgtInitViol"}, int'(tgtInitViol), int'(eTI));
    check({req, " tgtInitExtViol"}, int'(tgtInitExtViol), int'(eTX));
    check({req, " tgtSubViol"}, int'(tgtSubViol), int'(eTS));
    check({req, " lenViol"}, int'(lenViol), int'(eL));
  endtask

  task automatic idleBus();
    frameAct = 0; irdyAct = 0; trdyAct = 0; stopAct = 0; modHit = 0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 0; idleBus();
    repeat (2) @(negedge clk);
    rstN = 1;
    eM = 0; eTI = 0; eTX = 0; eTS = 0; eL = 0;
  endtask

  // One transaction: target answers on clock tFirst of phase 1 and tSub of later
  // phases; initiator ready on clock mWait of every phase. Checks end results.
  task automatic doTxn(input string req, input bit mh, input int nph, input int tFirst,
                       input int tSub, input int mWait, input bit useStop);
    int total = 0;
    int lim0 = mh ? 32 : 16;
    for (int p = 0; p < nph; p++) begin
      int tw = (p == 0) ? tFirst : tSub;
      int len = (tw > mWait) ? tw : mWait;
      if (mWait > 8) eM = 1;
      if (p == 0 && tw > lim0) begin if (mh) eTX = 1; else eTI = 1; end
      if (p > 0 && tw > 8) eTS = 1;
      for (int c = 1; c <= len; c++) begin
        @(negedge clk);
        frameAct = (total == 0) || (p < nph - 1);
        modHit   = (total == 0) ? mh : 1'b0;
        irdyAct  = (c >= mWait);
        trdyAct  = !useStop && (c >= tw);
        stopAct  = useStop && (c >= tw);
        total++;
      end
    end
    if (total > lim0 + 8 * (nph - 1)) eL = 1;
    @(negedge clk);
    idleBus();
    check({req, " txnDone"}, int'(txnDone), 1);
    check({req, " txnClocks"}, int'(txnClocks), total + 1);
    check({req, " txnPhases"}, int'(txnPhases), nph);
    checkFlags(req);
    @(negedge clk);
    check({req, " txnDone one clock"}, int'(txnDone), 0);
  endtask

  task automatic testReset();
    doReset();
    checkFlags("R1 reset");
    check("R1 txnClocks", int'(txnClocks), 0);
    check("R1 txnPhases", int'(txnPhases), 0);
    check("R1 txnDone", int'(txnDone), 0);
  endtask

  task automatic testClean();
    doReset();
    doTxn("R3 R9 clean burst", 0, 4, 5, 1, 1, 0);
    doTxn("R3 R9 waited burst", 0, 3, 3, 4, 2, 0);
  endtask

  task automatic testInitLimit();
    doReset();
    doTxn("R5 first phase on limit", 0, 2, 16, 1, 1, 0);
    doTxn("R5 R10 first phase late", 0, 1, 17, 1, 1, 0);
  endtask

  task automatic testExtLimit();
    doReset();
    doTxn("R6 modified hit 20", 1, 2, 20, 1, 1, 0);
    doTxn("R6 modified hit on limit", 1, 2, 32, 1, 1, 0);
    doTxn("R6 R10 modified hit late", 1, 1, 33, 1, 1, 0);
  endtask

  task automatic testSubLimit();
    doReset();
    doTxn("R7 later phase on limit", 0, 3, 2, 8, 1, 0);
    doTxn("R7 later phase late", 0, 3, 2, 9, 1, 0);
  endtask

  task automatic testMstrLimit();
    doReset();
    doTxn("R4 initiator on limit", 0, 2, 1, 1, 8, 0);
    doTxn("R4 initiator late", 0, 2, 1, 1, 9, 0);
  endtask

  task automatic testStop();
    doReset();
    doTxn("R8 stop answers", 0, 2, 16, 3, 1, 1);
    doTxn("R8 stop late", 0, 1, 17, 1, 1, 1);
  endtask

  task automatic testStickyRestart();
    doReset();
    doTxn("R11 violating txn", 0, 2, 1, 9, 1, 0);
    // new start while frame stays high on a busy clock must not restart (R2)
    @(negedge clk);
    frameAct = 1; modHit = 1;
    @(negedge clk);
    modHit = 0;
    check("R9 restart txnClocks", int'(txnClocks), 1);
    check("R9 restart txnPhases", int'(txnPhases), 0);
    checkFlags("R11 sticky after restart");
    @(negedge clk);
    check("R2 no restart while busy", int'(txnClocks), 2);
    irdyAct = 1; trdyAct = 1;
    @(negedge clk);
    frameAct = 0;
    @(negedge clk);
    idleBus();
    check("R9 restart done", int'(txnDone), 1);
    check("R9 restart total", int'(txnClocks), 5);
    check("R3 restart phases", int'(txnPhases), 2);
    checkFlags("R11 sticky at end");
  endtask

  initial begin
    rstN = 0;
    idleBus();
    testReset();
    testClean();
    testInitLimit();
    testExtLimit();
    testSubLimit();
    testMstrLimit();
    testStop();
    testStickyRestart();
    repeat (3) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule